// File: doc/BRIEF.md
# Binary/Decade Up/Down Counter with Carry

A synchronous 4-bit counter that counts either modulo 16 (binary) or modulo 10 (decade), upward or downward. The mode and direction are plain control pins, sampled at each rising clock edge. Counting is gated by an active-low carry input. An active-low carry output marks the terminal count for the current mode and direction. Wiring one stage's carry output to the next stage's carry input therefore builds a wider synchronous counter.

A level-sensitive preset enable overrides counting. While it is high, the output shows the jam inputs at once, with no clock edge needed. The internal register takes the jam value on every rising edge during that time. When preset is released, counting resumes from the last value captured. The block only counts: it has no data stream, so every pin is a plain level signal.

Top module: `bindec_updown_counter`

## Requirements
- R1: A high `rst` at a rising edge clears the count register to 0. `q` then reads 0 whenever `preset_en` is low.
- R2: With `bin_ndec`=1, `up_ndn`=1, `ncarry_in`=0 and `preset_en`=0, each rising edge adds 1 modulo 16, so 15 is followed by 0.
- R3: With `bin_ndec`=1, `up_ndn`=0 and counting enabled, each rising edge subtracts 1 modulo 16, so 0 is followed by 15.
- R4: With `bin_ndec`=0, `up_ndn`=1 and counting enabled, 0..8 step up by 1. A count of 9, and any illegal count from 10 to 15, steps to 0.
- R5: With `bin_ndec`=0, `up_ndn`=0 and counting enabled, 1..9 step down by 1. A count of 0 steps to 9, and any illegal count from 10 to 15 steps to 9.
- R6: While `ncarry_in`=1 (and `preset_en`=0), the count holds across clock edges.
- R7: While `preset_en`=1, `q` equals `jam` in the same time step, with no clock edge needed, and the count does not advance even if `ncarry_in`=0. After release, `q` holds the `jam` value present at the last rising edge before release.
- R8: `ncarry_out` is 0 exactly when `ncarry_in`=0 and `q` is at the terminal count. The terminal count is 15 for binary up, 9 for decade up, and 0 for down in either mode. Otherwise `ncarry_out` is 1. It is combinational in `q`, the mode, the direction and `ncarry_in`.
- R9: While `ncarry_in`=1, `ncarry_out` is 1 whatever the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear of the count register |
| bin_ndec | input | 1 | 1 = modulo 16, 0 = modulo 10 |
| up_ndn | input | 1 | 1 = count up, 0 = count down |
| ncarry_in | input | 1 | Active-low count enable / cascade carry input |
| preset_en | input | 1 | Level-sensitive load of `jam`; overrides counting |
| jam | input | 4 | Preset value |
| q | output | 4 | Current count |
| ncarry_out | output | 1 | Active-low terminal-count flag |

## Verification
Loading and counting can both be requested at one edge: `preset_en` high together with `ncarry_in` low and a non-terminal count. The bench provokes this by holding the preset across a rising edge while counting is enabled. It judges the result by `q` staying equal to `jam` rather than stepping, and by `q` still reading that value once the preset is released. The carry flag and the carry input also meet at the terminal count: the bench loads the terminal value with `ncarry_in` both low and high and checks that the count holds and `ncarry_out` stays high in the second case.

// File: rtl/bdcnt_pkg.sv
package bdcnt_pkg;
  localparam int CNT_W       = 4;
  localparam int DEC_MODULUS = 10;

  typedef enum logic {
    MODE_DEC = 1'b0,
    MODE_BIN = 1'b1
  } cnt_mode_e;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } cnt_dir_e;
endpackage

// File: rtl/bdcnt_step.sv
module bdcnt_step #(
  parameter int W       = bdcnt_pkg::CNT_W,
  parameter int DEC_MOD = bdcnt_pkg::DEC_MODULUS
) (
  input  logic [W-1:0] cur,
  input  logic         bin_mode,
  input  logic         dir_up,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] DEC_LAST = W'(DEC_MOD - 1);
  localparam logic [W-1:0] ONE      = W'(1);

  logic [W-1:0] inc_v;
  logic [W-1:0] dec_v;

  assign inc_v = cur + ONE;
  assign dec_v = cur - ONE;

  always_comb begin
    if (bin_mode) begin
      nxt = dir_up ? inc_v : dec_v;
    end else if (dir_up) begin
      // Illegal states above the decade range fall back to zero.
      nxt = (cur >= DEC_LAST) ? '0 : inc_v;
    end else begin
      if (cur == '0)           nxt = DEC_LAST;
      else if (cur > DEC_LAST) nxt = DEC_LAST;
      else                     nxt = dec_v;
    end
  end
endmodule

// File: rtl/bdcnt_term.sv
module bdcnt_term #(
  parameter int W       = bdcnt_pkg::CNT_W,
  parameter int DEC_MOD = bdcnt_pkg::DEC_MODULUS
) (
  input  logic [W-1:0] cur,
  input  logic         bin_mode,
  input  logic         dir_up,
  input  logic         ncarry_in,
  output logic         ncarry_out
);
  localparam logic [W-1:0] BIN_LAST = {W{1'b1}};
  localparam logic [W-1:0] DEC_LAST = W'(DEC_MOD - 1);

  logic [W-1:0] top_val;
  logic         at_end;

  assign top_val    = bin_mode ? BIN_LAST : DEC_LAST;
  assign at_end     = dir_up ? (cur == top_val) : (cur == '0);
  assign ncarry_out = ~(at_end & ~ncarry_in);
endmodule

// File: rtl/bindec_updown_counter.sv
module bindec_updown_counter #(
  parameter int W       = bdcnt_pkg::CNT_W,
  parameter int DEC_MOD = bdcnt_pkg::DEC_MODULUS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bin_ndec,
  input  logic         up_ndn,
  input  logic         ncarry_in,
  input  logic         preset_en,
  input  logic [W-1:0] jam,
  output logic [W-1:0] q,
  output logic         ncarry_out
);
  logic [W-1:0] cnt_r;
  logic [W-1:0] cnt_nxt;

  bdcnt_step #(.W(W), .DEC_MOD(DEC_MOD)) u_step (
    .cur      (cnt_r),
    .bin_mode (bin_ndec),
    .dir_up   (up_ndn),
    .nxt      (cnt_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)             cnt_r <= '0;
    else if (preset_en)  cnt_r <= jam;
    else if (!ncarry_in) cnt_r <= cnt_nxt;
  end

  // Preset is transparent to the output without waiting for an edge.
  assign q = preset_en ? jam : cnt_r;

  bdcnt_term #(.W(W), .DEC_MOD(DEC_MOD)) u_term (
    .cur        (q),
    .bin_mode   (bin_ndec),
    .dir_up     (up_ndn),
    .ncarry_in  (ncarry_in),
    .ncarry_out (ncarry_out)
  );
endmodule

// File: rtl/bdcnt_chk.sv
module bdcnt_chk #(
  parameter int W       = bdcnt_pkg::CNT_W,
  parameter int DEC_MOD = bdcnt_pkg::DEC_MODULUS
) (
  input logic         clk,
  input logic         rst,
  input logic         bin_ndec,
  input logic         up_ndn,
  input logic         ncarry_in,
  input logic         preset_en,
  input logic [W-1:0] jam,
  input logic [W-1:0] q,
  input logic         ncarry_out
);
  localparam logic [W-1:0] DEC_LAST = W'(DEC_MOD - 1);
  localparam logic [W-1:0] ONE      = W'(1);

  assert_clear_R1: assert property (@(posedge clk)
    rst |=> (preset_en || q == '0));

  assert_bin_up_R2: assert property (@(posedge clk) disable iff (rst)
    (!preset_en && !ncarry_in && bin_ndec && up_ndn)
      |=> (preset_en || q == W'($past(q) + ONE)));

  assert_bin_down_R3: assert property (@(posedge clk) disable iff (rst)
    (!preset_en && !ncarry_in && bin_ndec && !up_ndn)
      |=> (preset_en || q == W'($past(q) - ONE)));

  assert_dec_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (!preset_en && !ncarry_in && !bin_ndec && up_ndn && q >= DEC_LAST)
      |=> (preset_en || q == '0));

  assert_dec_under_R5: assert property (@(posedge clk) disable iff (rst)
    (!preset_en && !ncarry_in && !bin_ndec && !up_ndn && (q == '0 || q > DEC_LAST))
      |=> (preset_en || q == DEC_LAST));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!preset_en && ncarry_in) |=> (preset_en || $stable(q)));

  assert_preset_R7: assert property (@(posedge clk) disable iff (rst)
    preset_en |-> (q == jam));

  assert_release_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(preset_en) && !preset_en) |-> (q == $past(jam)));

  assert_term_low_R8: assert property (@(posedge clk) disable iff (rst)
    (!ncarry_in && !up_ndn && q == '0) |-> !ncarry_out);

  assert_carry_mask_R9: assert property (@(posedge clk) disable iff (rst)
    ncarry_in |-> ncarry_out);
endmodule

bind bindec_updown_counter bdcnt_chk #(.W(W), .DEC_MOD(DEC_MOD)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bin_ndec   (bin_ndec),
  .up_ndn     (up_ndn),
  .ncarry_in  (ncarry_in),
  .preset_en  (preset_en),
  .jam        (jam),
  .q          (q),
  .ncarry_out (ncarry_out)
);

// File: tb/bindec_updown_counter_test.sv
module bindec_updown_counter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bin_ndec = 1'b1;
  logic       up_ndn = 1'b1;
  logic       ncarry_in = 1'b1;
  logic       preset_en = 1'b0;
  logic [3:0] jam = 4'd0;
  logic [3:0] q;
  logic       ncarry_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bindec_updown_counter uut (
    .clk(clk), .rst(rst), .bin_ndec(bin_ndec), .up_ndn(up_ndn),
    .ncarry_in(ncarry_in), .preset_en(preset_en), .jam(jam),
    .q(q), .ncarry_out(ncarry_out)
  );

  // {tag, bin, up, ncin, start, next, nco_at_start}
  localparam int NV = 14;
  localparam logic [15:0] VEC [NV] = '{
    {4'd2, 1'b1, 1'b1, 1'b0, 4'd3,  4'd4,  1'b1},  // R2 plain step
    {4'd2, 1'b1, 1'b1, 1'b0, 4'd15, 4'd0,  1'b0},  // R2 wrap, R8 terminal
    {4'd3, 1'b1, 1'b0, 1'b0, 4'd0,  4'd15, 1'b0},  // R3 wrap, R8 terminal
    {4'd3, 1'b1, 1'b0, 1'b0, 4'd8,  4'd7,  1'b1},  // R3 plain step
    {4'd4, 1'b0, 1'b1, 1'b0, 4'd9,  4'd0,  1'b0},  // R4 wrap, R8 terminal
    {4'd4, 1'b0, 1'b1, 1'b0, 4'd4,  4'd5,  1'b1},  // R4 plain step
    {4'd4, 1'b0, 1'b1, 1'b0, 4'd12, 4'd0,  1'b1},  // R4 illegal recovery
    {4'd5, 1'b0, 1'b0, 1'b0, 4'd0,  4'd9,  1'b0},  // R5 wrap, R8 terminal
    {4'd5, 1'b0, 1'b0, 1'b0, 4'd13, 4'd9,  1'b1},  // R5 illegal recovery
    {4'd5, 1'b0, 1'b0, 1'b0, 4'd5,  4'd4,  1'b1},  // R5 plain step
    {4'd6, 1'b1, 1'b1, 1'b1, 4'd15, 4'd15, 1'b1},  // R6 hold, R9 mask
    {4'd6, 1'b0, 1'b0, 1'b1, 4'd0,  4'd0,  1'b1},  // R6 hold, R9 mask
    {4'd8, 1'b1, 1'b1, 1'b0, 4'd9,  4'd10, 1'b1},  // R8 nine not terminal in binary
    {4'd8, 1'b0, 1'b1, 1'b0, 4'd15, 4'd0,  1'b1}   // R8 fifteen not terminal in decade
  };

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset q", q, 4'd0);
    check("R9 reset carry", {3'b0, ncarry_out}, 4'd1);
    rst = 1'b0;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bin_ndec  = VEC[i][11];
      up_ndn    = VEC[i][10];
      ncarry_in = VEC[i][9];
      jam       = VEC[i][8:5];
      preset_en = 1'b1;
      @(negedge clk);
      preset_en = 1'b0;
      #1;
      check($sformatf("R%0d carry vec %0d", VEC[i][15:12], i),
            {3'b0, ncarry_out}, {3'b0, VEC[i][0]});
      @(negedge clk);
      check($sformatf("R%0d next vec %0d", VEC[i][15:12], i), q, VEC[i][4:1]);
    end

    // R4 full decade run from 0: twelve steps
    @(negedge clk);
    bin_ndec = 1'b0; up_ndn = 1'b1; ncarry_in = 1'b0;
    jam = 4'd0; preset_en = 1'b1;
    @(negedge clk);
    preset_en = 1'b0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      check("R4 decade run", q, 4'(k % 10));
    end

    // R7 transparent preset without an edge, and load beats count
    @(posedge clk);
    #1;
    preset_en = 1'b1; jam = 4'd11;
    #1;
    check("R7 preset transparent", q, 4'd11);
    jam = 4'd6;
    #1;
    check("R7 preset follows jam", q, 4'd6);
    @(negedge clk);
    @(negedge clk);
    check("R7 load beats count", q, 4'd6);
    preset_en = 1'b0;
    #1;
    check("R7 value kept after release", q, 4'd6);
    @(negedge clk);
    check("R4 count resumes after preset", q, 4'd7);

    // R8 live carry in decade down at zero
    up_ndn = 1'b0; jam = 4'd0; preset_en = 1'b1;
    @(negedge clk);
    preset_en = 1'b0;
    #1;
    check("R8 down terminal carry", {3'b0, ncarry_out}, 4'd0);
    ncarry_in = 1'b1;
    #1;
    check("R9 carry masked", {3'b0, ncarry_out}, 4'd1);

    // R1 mid-run reset
    ncarry_in = 1'b0; bin_ndec = 1'b1; up_ndn = 1'b1;
    jam = 4'd5; preset_en = 1'b1;
    @(negedge clk);
    preset_en = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run clear", q, 4'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 count after reset", q, 4'd1);

    finish_run();
  end
endmodule